// File: doc/BRIEF.md
# Pulse Peak Feature Extractor

This block watches a stream of digitised detector samples, at most one per clock, and turns each pulse in that stream into one summary record. A pulse is the run of consecutive accepted samples that lie strictly above a programmable threshold. Inside that run, the block looks for local maxima by tracking the sign of the difference between each sample and the one before it.

When the run ends, the block emits one record. The record holds four features:
- the time of the largest local maximum, taken from a free-running cycle counter;
- the value of that maximum;
- the summed excess of the samples over a programmable pedestal;
- the number of samples in the run.

A parameter can also attach to each record the raw samples that end at the chosen maximum.

Records leave through a valid/ready output register. A record that completes while the previous one is still waiting is discarded, and a saturating drop counter counts each discard. A sample strobe qualifies the input, so idle cycles in the stream change nothing.

Top module: `pulse_feat_extract`

## Requirements
- R1: While reset is asserted and right after it, `rec_valid` is 0 and `drop_count` is 0.
- R2: `rec_tot` equals the number of consecutive accepted samples strictly above `thresh`, saturating at 2^LEN_W-1. The record becomes valid on the clock edge that accepts the first sample at or below `thresh`.
- R3: A local peak is an accepted sample that is strictly greater than the one before it and not smaller than the one after it. When a pulse has several local peaks, the record keeps the largest one, and on a tie it keeps the earliest.
- R4: `rec_time` equals the number of rising clock edges with reset inactive that came before the edge that accepted the kept peak sample.
- R5: `rec_area` is the sum over the pulse samples of max(0, sample − `pedestal`), saturating at 2^AREA_W-1.
- R6: Cycles with `smp_valid` low have no effect on any feature, whatever `smp_data` carries during them.
- R7: While `rec_valid` is 1 and `rec_ready` is 0, the record fields stay unchanged and `rec_valid` stays 1.
- R8: A pulse that ends while a record is pending and not ready is discarded. In that case `drop_count` rises by one, saturating, and the pending record is left as it was.
- R9: `rec_win` bits [k*SW +: SW] hold the accepted sample k positions before the kept peak, with k = 0 being the peak itself. Positions that reach back before the first sample since reset read 0.
- R10: On a flat top, where equal samples follow a rise, the first sample of the flat run is the peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Qualifies `smp_data` on this cycle |
| smp_data | input | SW | Unsigned sample |
| thresh | input | SW | Pulse threshold, compared strictly |
| pedestal | input | SW | Level subtracted before summing |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_time | output | TS_W | Timestamp of the kept peak |
| rec_peak | output | SW | Value of the kept peak |
| rec_area | output | AREA_W | Saturated summed excess |
| rec_tot | output | LEN_W | Samples above threshold |
| rec_win | output | WIN_LEN*SW | Raw samples ending at the peak |
| drop_count | output | OVF_W | Saturating count of discarded records |

## Verification
The hardest case to reach is a pulse that ends while the previous record is still stalled, because it needs the consumer held off across a whole second pulse. The stimulus holds `rec_ready` low, drives one complete pulse, checks that its record stays frozen, and then drives a second pulse to its end. The bench checks the drop counter, confirms that the first record is still intact, and only then releases ready to drain that first record and nothing more. Saturation of the area sum is reached with a 70-sample full-scale plateau, which is longer than the sized maximum pulse.

// File: rtl/pulse_feat_pkg.sv
package pulse_feat_pkg;

  // amount by which a sample exceeds the pedestal, never negative
  function automatic longint unsigned excess_u(longint unsigned x, longint unsigned ped);
    return (x > ped) ? (x - ped) : 64'd0;
  endfunction

  // addition clamped to a ceiling
  function automatic longint unsigned sat_add_u(longint unsigned a, longint unsigned b,
                                                longint unsigned lim);
    longint unsigned s;
    s = a + b;
    return (s > lim) ? lim : s;
  endfunction

endpackage

// File: rtl/pulse_feat_slope.sv
module pulse_feat_slope #(
  parameter int SW      = 12,
  parameter int TS_W    = 32,
  parameter int WIN_LEN = 4,
  parameter bit WIN_EN  = 1'b1,
  localparam int WB     = WIN_LEN * SW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic [SW-1:0]   smp_data,
  input  logic [TS_W-1:0] ts_now,
  output logic            peak_hit,
  output logic [SW-1:0]   pk_val,
  output logic [TS_W-1:0] pk_ts,
  output logic [WB-1:0]   pk_win
);

  logic [SW-1:0]   prev_q;
  logic            rising_q;
  logic [TS_W-1:0] prev_ts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      rising_q  <= 1'b0;
      prev_ts_q <= '0;
    end else if (smp_valid) begin
      prev_q    <= smp_data;
      rising_q  <= (smp_data > prev_q);
      prev_ts_q <= ts_now;
    end
  end

  // previous sample was reached by a rise and the current one does not rise further
  assign peak_hit = smp_valid && rising_q && (smp_data <= prev_q);
  assign pk_val   = prev_q;
  assign pk_ts    = prev_ts_q;

  generate
    if (WIN_EN) begin : g_win
      logic [SW-1:0] hist_q [WIN_LEN];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < WIN_LEN; i++) hist_q[i] <= '0;
        end else if (smp_valid) begin
          hist_q[0] <= smp_data;
          for (int i = 1; i < WIN_LEN; i++) hist_q[i] <= hist_q[i-1];
        end
      end
      for (genvar k = 0; k < WIN_LEN; k++) begin : g_slice
        assign pk_win[k*SW +: SW] = hist_q[k];
      end
    end else begin : g_nowin
      assign pk_win = '0;
    end
  endgenerate

endmodule

// File: rtl/pulse_feat_region.sv
module pulse_feat_region
  import pulse_feat_pkg::*;
#(
  parameter int SW      = 12,
  parameter int TS_W    = 32,
  parameter int AREA_W  = 18,
  parameter int LEN_W   = 7,
  parameter int WB      = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SW-1:0]     smp_data,
  input  logic [SW-1:0]     thresh,
  input  logic [SW-1:0]     pedestal,
  input  logic              peak_hit,
  input  logic [SW-1:0]     pk_val,
  input  logic [TS_W-1:0]   pk_ts,
  input  logic [WB-1:0]     pk_win,
  output logic              done,
  output logic              cand,
  output logic [TS_W-1:0]   fin_ts,
  output logic [SW-1:0]     fin_pk,
  output logic [AREA_W-1:0] fin_area,
  output logic [LEN_W-1:0]  fin_tot,
  output logic [WB-1:0]     fin_win
);

  localparam longint unsigned AREA_MAX = (64'd1 << AREA_W) - 64'd1;
  localparam longint unsigned TOT_MAX  = (64'd1 << LEN_W) - 64'd1;

  logic              in_reg_q, have_best_q;
  logic [AREA_W-1:0] acc_q;
  logic [LEN_W-1:0]  tot_q;
  logic [SW-1:0]     best_pk_q;
  logic [TS_W-1:0]   best_ts_q;
  logic [WB-1:0]     best_win_q;
  logic              above, take;
  logic [AREA_W-1:0] acc_next;
  logic [LEN_W-1:0]  tot_next;

  always_comb begin
    above    = smp_data > thresh;
    cand     = peak_hit && in_reg_q;
    take     = cand && (!have_best_q || (pk_val > best_pk_q));
    done     = smp_valid && in_reg_q && !above;
    acc_next = AREA_W'(sat_add_u(64'(acc_q), excess_u(64'(smp_data), 64'(pedestal)), AREA_MAX));
    tot_next = LEN_W'(sat_add_u(64'(tot_q), 64'd1, TOT_MAX));
    fin_pk   = take ? pk_val : best_pk_q;
    fin_ts   = take ? pk_ts  : best_ts_q;
    fin_win  = take ? pk_win : best_win_q;
    fin_area = acc_q;
    fin_tot  = tot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reg_q    <= 1'b0;
      have_best_q <= 1'b0;
      acc_q       <= '0;
      tot_q       <= '0;
      best_pk_q   <= '0;
      best_ts_q   <= '0;
      best_win_q  <= '0;
    end else if (smp_valid) begin
      if (above) begin
        if (!in_reg_q) begin
          in_reg_q    <= 1'b1;
          have_best_q <= 1'b0;
          acc_q       <= AREA_W'(sat_add_u(64'd0, excess_u(64'(smp_data), 64'(pedestal)), AREA_MAX));
          tot_q       <= LEN_W'(1);
        end else begin
          acc_q <= acc_next;
          tot_q <= tot_next;
          if (take) begin
            have_best_q <= 1'b1;
            best_pk_q   <= pk_val;
            best_ts_q   <= pk_ts;
            best_win_q  <= pk_win;
          end
        end
      end else begin
        in_reg_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pulse_feat_outreg.sv
module pulse_feat_outreg #(
  parameter int SW     = 12,
  parameter int TS_W   = 32,
  parameter int AREA_W = 18,
  parameter int LEN_W  = 7,
  parameter int WB     = 48,
  parameter int OVF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [TS_W-1:0]   in_ts,
  input  logic [SW-1:0]     in_pk,
  input  logic [AREA_W-1:0] in_area,
  input  logic [LEN_W-1:0]  in_tot,
  input  logic [WB-1:0]     in_win,
  input  logic              rec_ready,
  output logic              rec_valid,
  output logic [TS_W-1:0]   rec_time,
  output logic [SW-1:0]     rec_peak,
  output logic [AREA_W-1:0] rec_area,
  output logic [LEN_W-1:0]  rec_tot,
  output logic [WB-1:0]     rec_win,
  output logic [OVF_W-1:0]  drop_count,
  output logic              load_evt,
  output logic              drop_evt
);

  assign load_evt = done && (!rec_valid || rec_ready);
  assign drop_evt = done && rec_valid && !rec_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid  <= 1'b0;
      rec_time   <= '0;
      rec_peak   <= '0;
      rec_area   <= '0;
      rec_tot    <= '0;
      rec_win    <= '0;
      drop_count <= '0;
    end else begin
      if (load_evt) begin
        rec_valid <= 1'b1;
        rec_time  <= in_ts;
        rec_peak  <= in_pk;
        rec_area  <= in_area;
        rec_tot   <= in_tot;
        rec_win   <= in_win;
      end else if (rec_ready) begin
        rec_valid <= 1'b0;
      end
      if (drop_evt && (drop_count != '1)) drop_count <= drop_count + 1'b1;
    end
  end

endmodule

// File: rtl/pulse_feat_extract.sv
module pulse_feat_extract #(
  parameter int SW      = 12,
  parameter int TS_W    = 32,
  parameter int MAX_LEN = 64,
  parameter int WIN_LEN = 4,
  parameter bit WIN_EN  = 1'b1,
  parameter int OVF_W   = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int AREA_W = $clog2(MAX_LEN * ((1 << SW) - 1) + 1),
  localparam int WB     = WIN_LEN * SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SW-1:0]     smp_data,
  input  logic [SW-1:0]     thresh,
  input  logic [SW-1:0]     pedestal,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [TS_W-1:0]   rec_time,
  output logic [SW-1:0]     rec_peak,
  output logic [AREA_W-1:0] rec_area,
  output logic [LEN_W-1:0]  rec_tot,
  output logic [WB-1:0]     rec_win,
  output logic [OVF_W-1:0]  drop_count
);

  logic [TS_W-1:0]   ts_q;
  logic              peak_hit, peak_evt, done_evt, load_evt, drop_evt;
  logic [SW-1:0]     pk_val, fin_pk;
  logic [TS_W-1:0]   pk_ts, fin_ts;
  logic [WB-1:0]     pk_win, fin_win;
  logic [AREA_W-1:0] fin_area;
  logic [LEN_W-1:0]  fin_tot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_q + 1'b1;
  end

  pulse_feat_slope #(.SW(SW), .TS_W(TS_W), .WIN_LEN(WIN_LEN), .WIN_EN(WIN_EN)) slope_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data), .ts_now(ts_q),
    .peak_hit(peak_hit), .pk_val(pk_val), .pk_ts(pk_ts), .pk_win(pk_win)
  );

  pulse_feat_region #(.SW(SW), .TS_W(TS_W), .AREA_W(AREA_W), .LEN_W(LEN_W), .WB(WB)) region_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .thresh(thresh), .pedestal(pedestal), .peak_hit(peak_hit), .pk_val(pk_val),
    .pk_ts(pk_ts), .pk_win(pk_win), .done(done_evt), .cand(peak_evt),
    .fin_ts(fin_ts), .fin_pk(fin_pk), .fin_area(fin_area), .fin_tot(fin_tot), .fin_win(fin_win)
  );

  pulse_feat_outreg #(.SW(SW), .TS_W(TS_W), .AREA_W(AREA_W), .LEN_W(LEN_W), .WB(WB),
                      .OVF_W(OVF_W)) out_i (
    .clk(clk), .rst_n(rst_n), .done(done_evt), .in_ts(fin_ts), .in_pk(fin_pk),
    .in_area(fin_area), .in_tot(fin_tot), .in_win(fin_win), .rec_ready(rec_ready),
    .rec_valid(rec_valid), .rec_time(rec_time), .rec_peak(rec_peak), .rec_area(rec_area),
    .rec_tot(rec_tot), .rec_win(rec_win), .drop_count(drop_count),
    .load_evt(load_evt), .drop_evt(drop_evt)
  );

endmodule

// File: rtl/pulse_feat_extract_chk.sv
module pulse_feat_extract_chk #(
  parameter int SW     = 12,
  parameter int TS_W   = 32,
  parameter int AREA_W = 18,
  parameter int LEN_W  = 7,
  parameter int OVF_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rec_valid,
  input logic              rec_ready,
  input logic [TS_W-1:0]   rec_time,
  input logic [SW-1:0]     rec_peak,
  input logic [AREA_W-1:0] rec_area,
  input logic [LEN_W-1:0]  rec_tot,
  input logic [OVF_W-1:0]  drop_count,
  input logic              done_evt,
  input logic              drop_evt,
  input logic              load_evt
);

  // R7
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_time) && $stable(rec_peak)
                                   && $stable(rec_area) && $stable(rec_tot)));

  // R8
  drop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && (drop_count != '1)) |=> (drop_count == $past(drop_count) + 1'b1));

  // R8
  drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count >= $past(drop_count)));

  // R2
  tot_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_tot != '0));

  // R2
  emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid) |-> $past(done_evt));

  // R8
  load_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_evt && drop_evt));

endmodule

bind pulse_feat_extract pulse_feat_extract_chk #(
  .SW(SW), .TS_W(TS_W), .AREA_W(AREA_W), .LEN_W(LEN_W), .OVF_W(OVF_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_time(rec_time), .rec_peak(rec_peak), .rec_area(rec_area), .rec_tot(rec_tot),
  .drop_count(drop_count), .done_evt(done_evt), .drop_evt(drop_evt), .load_evt(load_evt)
);

// File: tb/pulse_feat_extract_tb.sv
module pulse_feat_extract_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 12, TS_W = 32, WIN_LEN = 4;
  localparam int AREA_W = 18, LEN_W = 7, OVF_W = 8, WB = WIN_LEN * SW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, rec_ready = 1'b1;
  logic [SW-1:0] smp_data = '0, thresh = 12'd100, pedestal = 12'd20;
  logic rec_valid;
  logic [TS_W-1:0] rec_time;
  logic [SW-1:0] rec_peak;
  logic [AREA_W-1:0] rec_area;
  logic [LEN_W-1:0] rec_tot;
  logic [WB-1:0] rec_win;
  logic [OVF_W-1:0] drop_count;

  int checks = 0, errors = 0, cycles = 0;
  longint bcyc = 0;
  longint tsq [512];
  int nput = 0;
  longint cap_time [32], cap_peak [32], cap_area [32], cap_tot [32];
  logic [WB-1:0] cap_win [32];
  int nrec = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_feat_extract dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .thresh(thresh), .pedestal(pedestal), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_time(rec_time), .rec_peak(rec_peak), .rec_area(rec_area), .rec_tot(rec_tot),
    .rec_win(rec_win), .drop_count(drop_count)
  );

  // reference cycle count: edges seen with reset inactive
  always @(posedge clk) begin
    if (!rst_n) bcyc <= 0;
    else        bcyc <= bcyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n && rec_valid && rec_ready && nrec < 32) begin
      cap_time[nrec] = rec_time;
      cap_peak[nrec] = rec_peak;
      cap_area[nrec] = rec_area;
      cap_tot[nrec]  = rec_tot;
      cap_win[nrec]  = rec_win;
      nrec++;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(int x);
    tsq[nput] = bcyc;
    nput++;
    smp_valid = 1'b1;
    smp_data  = SW'(x);
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  task automatic gap(int junk);
    smp_valid = 1'b0;
    smp_data  = SW'(junk);
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check_last(string req, int n_before, longint ts, longint pk, longint area, longint tot);
    check(req, "record count", nrec, n_before + 1);
    if (nrec > 0) begin
      check(req, "time", cap_time[nrec-1], ts);
      check(req, "peak", cap_peak[nrec-1], pk);
      check("R5", "area", cap_area[nrec-1], area);
      check("R2", "tot", cap_tot[nrec-1], tot);
    end
  endtask

  task automatic t_reset();
    check("R1", "rec_valid in reset", rec_valid, 0);
    check("R1", "drop_count in reset", drop_count, 0);
  endtask

  task automatic t_single();
    int n0 = nrec, b;
    b = nput;
    put(10); put(50); put(150); put(300); put(200);
    // R2: record valid right after the edge taking the ending sample
    put(90);
    @(negedge clk);
    check("R2", "valid after end edge", rec_valid, 1);
    idle(2); put(30); idle(2);
    check_last("R4", n0, tsq[b+3], 300, 130 + 280 + 180, 3);
    if (nrec > 0) begin
      check("R9", "win slice0", cap_win[nrec-1][0*SW +: SW], 300);
      check("R9", "win slice1", cap_win[nrec-1][1*SW +: SW], 150);
      check("R9", "win slice2", cap_win[nrec-1][2*SW +: SW], 50);
      check("R9", "win slice3", cap_win[nrec-1][3*SW +: SW], 10);
    end
  endtask

  task automatic t_double();
    int n0 = nrec, b;
    b = nput;
    put(120); put(400); put(250); put(350); put(180); put(50); idle(3);
    check_last("R3", n0, tsq[b+1], 400, 100 + 380 + 230 + 330 + 160, 5);
    n0 = nrec; b = nput;
    put(300); put(200); put(300); put(50); idle(3);
    // R3 tie: the earliest of two equal peaks is kept
    check_last("R3", n0, tsq[b], 300, 280 + 180 + 280, 3);
  endtask

  task automatic t_gaps();
    int n0 = nrec, b;
    b = nput;
    put(0); put(150); gap(4000); gap(4095); put(260); gap(4000); put(180); gap(3000); put(60);
    idle(3);
    check_last("R6", n0, tsq[b+2], 260, 130 + 240 + 160, 3);
  endtask

  task automatic t_plateau();
    int n0 = nrec, b;
    b = nput;
    put(500); put(500); put(500); put(50); idle(3);
    check_last("R10", n0, tsq[b], 500, 480 * 3, 3);
  endtask

  task automatic t_stall();
    int n0 = nrec, b;
    rec_ready = 1'b0;
    b = nput;
    put(0); put(200); put(0); idle(1);
    check("R7", "pending valid", rec_valid, 1);
    idle(4);
    check("R7", "held valid", rec_valid, 1);
    check("R7", "held peak", rec_peak, 200);
    check("R7", "held time", rec_time, tsq[b+1]);
    put(300); put(0); idle(2);
    check("R8", "drop count", drop_count, 1);
    check("R8", "pending peak kept", rec_peak, 200);
    check("R8", "nothing taken while stalled", nrec, n0);
    rec_ready = 1'b1;
    idle(4);
    check("R8", "one record drained", nrec, n0 + 1);
    if (nrec > 0) check("R8", "drained peak", cap_peak[nrec-1], 200);
    check("R8", "valid clears", rec_valid, 0);
  endtask

  task automatic t_sat();
    int n0 = nrec, b;
    pedestal = '0;
    b = nput;
    put(0);
    for (int i = 0; i < 70; i++) put(4095);
    put(0); idle(3);
    check_last("R5", n0, tsq[b+1], 4095, (1 << AREA_W) - 1, 70);
    pedestal = 12'd20;
  endtask

  initial begin
    #1;
    idle(4);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_single();
    t_double();
    t_gaps();
    t_plateau();
    t_stall();
    t_sat();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule